// File: doc/BRIEF.md
# Latched Input Transition Interrupt Controller

This block watches a small group of open-drain ports that are used as inputs. It keeps a snapshot of their levels. Whenever a live level differs from its snapshot bit, the block latches a per-port change flag and pulls an active-low interrupt line. The flag stays set even if the level goes back before software looks at it, so a short pulse on a port is not lost.

The serial slave that sits beside this block reports bus events to it as single-cycle strobes. These are: the address acknowledge for the port group, the acknowledge that opens each later port/flag byte pair in a long read, an address that the master abandons with a not-acknowledge, and STOP. The slave also drives a level that is high while a read is in progress. From these events the block reloads the snapshot, hands the old flags to the shifter as the flag byte, and releases the interrupt.

While a read is running, a new change does not pull the interrupt. The change is held until STOP and raised there. If the master has already received the changed level in a later byte pair, nothing is raised at STOP.

Top module: `xition_irq_ctrl`

## Requirements
- R1: While `por` is high, `int_n` becomes 1, `flag_byte` becomes 0 and the snapshot loads the current port levels.
- R2: When no read is in progress and no bus event is present, a port whose level differs from its snapshot bit drives `int_n` low one clock later.
- R3: Once low, `int_n` stays low after the port level returns to its snapshot value. The change is still reported in the flags.
- R4: A `grp_a_addr_ack` strobe does four things. It drives `int_n` high on the next clock. It loads `flag_byte` with the flags accumulated so far, with bit i standing for port i. It clears the flags. It reloads the snapshot, so a level that is held afterwards raises no new interrupt.
- R5: `flag_byte` holds its value until the next `grp_a_addr_ack` or `pair_ack`.
- R6: While `rd_active` is high, a port change does not pull `int_n` low.
- R7: On `stop_det`, `int_n` goes low on the next clock if any port changed after the last snapshot load. This includes a change that has already reverted.
- R8: A `pair_ack` strobe reloads the snapshot, loads `flag_byte` with the accumulated flags and clears them. A change already covered by such a reload raises no interrupt at the following STOP.
- R9: An `addr_nack` strobe reloads the snapshot but leaves `int_n` and the accumulated flags as they were. The next `grp_a_addr_ack` still reports those flags.
- R10: Only `grp_a_addr_ack` or `por` releases a low `int_n`. `stop_det`, `pair_ack` and `addr_nack` do not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on reset |
| port_lvl | input | PORTS | Synchronized live port levels |
| grp_a_addr_ack | input | 1 | Strobe: port group address acknowledged (read or write) |
| pair_ack | input | 1 | Strobe: acknowledge that starts the next port/flag pair of a read |
| addr_nack | input | 1 | Strobe: master abandoned the access with a not-acknowledge |
| rd_active | input | 1 | High while a read of the group is in progress |
| stop_det | input | 1 | Strobe: STOP condition seen on the bus |
| flag_byte | output | PORTS | Flags captured at the last sample, for the serial shifter |
| int_n | output | 1 | Active-low latched interrupt |

## Verification
The bench applies a set of port patterns, each of which separates one kind of behaviour from another:
- A steady level, against a change outside a read, shows that the interrupt is driven by change and not by level.
- A pulse that reverts before the next access shows that both the flags and the interrupt are latched.
- A change held across a write acknowledge shows that the snapshot reload stops a held level from raising the interrupt again.
- A change inside a read, with and without a following byte-pair reload, separates a deferred interrupt at STOP from a suppressed one.
- A change that reverts inside a read covers the case where the level is back at the snapshot value when STOP arrives but the interrupt must still be raised.
- A not-acknowledge after the address, followed by a later acknowledge, shows that the flags and the interrupt survive an abandoned access.

// File: rtl/xition_irq_pkg.sv
package xition_irq_pkg;

    localparam int unsigned DEF_PORTS = 4;

    // Decoded bus events delivered to the datapath for one clock
    typedef struct packed {
        logic sample;      // reload snapshot from live levels
        logic take_flags;  // capture flags for the shifter and clear them
        logic release_irq; // drive interrupt inactive
        logic stop;        // STOP condition
        logic reading;     // a read is in progress
    } bus_evt_t;

    function automatic bus_evt_t decode_evt(
        input logic addr_ack,
        input logic pair_ack,
        input logic nack,
        input logic stop_det,
        input logic rd_active
    );
        bus_evt_t e;
        e.sample      = addr_ack | pair_ack | nack;
        e.take_flags  = addr_ack | pair_ack;
        e.release_irq = addr_ack;
        e.stop        = stop_det;
        e.reading     = rd_active;
        return e;
    endfunction

endpackage

// File: rtl/xition_evt_decode.sv
module xition_evt_decode
    import xition_irq_pkg::*;
(
    input  logic     addr_ack,
    input  logic     pair_ack,
    input  logic     nack,
    input  logic     stop_det,
    input  logic     rd_active,
    output bus_evt_t evt
);
    always_comb begin
        evt = decode_evt(addr_ack, pair_ack, nack, stop_det, rd_active);
    end
endmodule

// File: rtl/xition_snap_bank.sv
module xition_snap_bank
    import xition_irq_pkg::*;
#(
    parameter int unsigned PORTS = DEF_PORTS
) (
    input  logic             clk,
    input  logic             por,
    input  logic [PORTS-1:0] port_lvl,
    input  bus_evt_t         evt,
    output logic [PORTS-1:0] diff,
    output logic [PORTS-1:0] pend,
    output logic [PORTS-1:0] flag_cap
);
    for (genvar i = 0; i < PORTS; i++) begin : g_cell
        logic snap_q;
        logic flg_q;
        logic pend_q;
        logic cap_q;
        logic d;

        assign d = port_lvl[i] ^ snap_q;

        always_ff @(posedge clk) begin
            if (por) begin
                snap_q <= port_lvl[i];
                flg_q  <= 1'b0;
                pend_q <= 1'b0;
                cap_q  <= 1'b0;
            end else if (evt.sample) begin
                snap_q <= port_lvl[i];
                pend_q <= 1'b0;
                if (evt.take_flags) begin
                    cap_q <= flg_q | d;
                    flg_q <= 1'b0;
                end else begin
                    flg_q <= flg_q | d;
                end
            end else begin
                flg_q  <= flg_q | d;
                pend_q <= pend_q | d;
            end
        end

        assign diff[i]     = d;
        assign pend[i]     = pend_q;
        assign flag_cap[i] = cap_q;
    end
endmodule

// File: rtl/xition_int_latch.sv
module xition_int_latch
    import xition_irq_pkg::*;
#(
    parameter int unsigned PORTS = DEF_PORTS
) (
    input  logic             clk,
    input  logic             por,
    input  bus_evt_t         evt,
    input  logic [PORTS-1:0] diff,
    input  logic [PORTS-1:0] pend,
    output logic             int_n
);
    logic int_q;
    logic por_d;

    always_ff @(posedge clk) begin
        if (por) begin
            int_q <= 1'b1;
        end else if (evt.release_irq) begin
            int_q <= 1'b1;
        end else if (evt.stop && ((|pend) || (|diff))) begin
            int_q <= 1'b0;
        end else if (!evt.reading && (|diff)) begin
            int_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        por_d <= por;
    end

    assign int_n = int_q;

    // R1
    always_ff @(posedge clk) begin
        if (por_d) begin
            rst_release_chk: assert (int_q == 1'b1);
        end
    end

    // R4
    addr_ack_release_chk: assert property (@(posedge clk) disable iff (por)
        evt.release_irq |=> int_q);

    // R6
    read_hold_chk: assert property (@(posedge clk) disable iff (por)
        (evt.reading && !evt.stop && int_q) |=> int_q);

    // R10
    latched_low_chk: assert property (@(posedge clk) disable iff (por)
        (!int_q && !evt.release_irq) |=> !int_q);
endmodule

// File: rtl/xition_irq_ctrl.sv
module xition_irq_ctrl
    import xition_irq_pkg::*;
#(
    parameter int unsigned PORTS = DEF_PORTS
) (
    input  logic             clk,
    input  logic             por,
    input  logic [PORTS-1:0] port_lvl,
    input  logic             grp_a_addr_ack,
    input  logic             pair_ack,
    input  logic             addr_nack,
    input  logic             rd_active,
    input  logic             stop_det,
    output logic [PORTS-1:0] flag_byte,
    output logic             int_n
);
    bus_evt_t         evt;
    logic [PORTS-1:0] diff;
    logic [PORTS-1:0] pend;

    xition_evt_decode u_dec (
        .addr_ack  (grp_a_addr_ack),
        .pair_ack  (pair_ack),
        .nack      (addr_nack),
        .stop_det  (stop_det),
        .rd_active (rd_active),
        .evt       (evt)
    );

    xition_snap_bank #(.PORTS(PORTS)) u_snap (
        .clk      (clk),
        .por      (por),
        .port_lvl (port_lvl),
        .evt      (evt),
        .diff     (diff),
        .pend     (pend),
        .flag_cap (flag_byte)
    );

    xition_int_latch #(.PORTS(PORTS)) u_int (
        .clk   (clk),
        .por   (por),
        .evt   (evt),
        .diff  (diff),
        .pend  (pend),
        .int_n (int_n)
    );

    // R2
    idle_change_chk: assert property (@(posedge clk) disable iff (por)
        (!rd_active && !grp_a_addr_ack && !pair_ack && !addr_nack && !stop_det
         && (diff != '0)) |=> !int_n);

    // R7
    stop_pending_chk: assert property (@(posedge clk) disable iff (por)
        (stop_det && !grp_a_addr_ack && (pend != '0)) |=> !int_n);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (por)
        (!grp_a_addr_ack && !pair_ack) |=> $stable(flag_byte));
endmodule

// File: tb/xition_irq_ctrl_tb_top.sv
module xition_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic [3:0] port_lvl = 4'b1111;
    logic       grp_a_addr_ack = 1'b0;
    logic       pair_ack = 1'b0;
    logic       addr_nack = 1'b0;
    logic       rd_active = 1'b0;
    logic       stop_det = 1'b0;
    logic [3:0] flag_byte;
    logic       int_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        string      req;
        logic       exp_int;
        bit         chk_flg;
        logic [3:0] exp_flg;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    xition_irq_ctrl #(.PORTS(4)) dut_i (
        .clk            (clk),
        .por            (por),
        .port_lvl       (port_lvl),
        .grp_a_addr_ack (grp_a_addr_ack),
        .pair_ack       (pair_ack),
        .addr_nack      (addr_nack),
        .rd_active      (rd_active),
        .stop_det       (stop_det),
        .flag_byte      (flag_byte),
        .int_n          (int_n)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string r, input logic i, input bit cf, input logic [3:0] f);
        item_t it;
        it.req = r;
        it.exp_int = i;
        it.chk_flg = cf;
        it.exp_flg = f;
        sb_q.push_back(it);
    endtask

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (int_n !== it.exp_int) begin
                n_fail++;
                $display("FAIL %s int_n actual=%b expected=%b", it.req, int_n, it.exp_int);
            end
            if (it.chk_flg && (flag_byte !== it.exp_flg)) begin
                n_fail++;
                $display("FAIL %s flag_byte actual=%b expected=%b", it.req, flag_byte, it.exp_flg);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        expect_out("R1 reset", 1'b1, 1, 4'b0000);
        por = 1'b0;
        step();
        expect_out("R2 steady level", 1'b1, 1, 4'b0000);

        port_lvl = 4'b1011;
        step();
        expect_out("R2 idle change", 1'b0, 0, 4'b0000);
        port_lvl = 4'b1111;
        step(); step();
        expect_out("R3 transient latched", 1'b0, 0, 4'b0000);

        // read access
        rd_active = 1'b1;
        grp_a_addr_ack = 1'b1;
        step();
        grp_a_addr_ack = 1'b0;
        expect_out("R4 read ack release", 1'b1, 1, 4'b0100);
        port_lvl = 4'b1110;
        step(); step();
        expect_out("R6 change in read held", 1'b1, 1, 4'b0100);
        rd_active = 1'b0;
        stop_det = 1'b1;
        step();
        stop_det = 1'b0;
        expect_out("R7 deferred to stop", 1'b0, 1, 4'b0100);
        step();
        expect_out("R5 flag byte held", 1'b0, 1, 4'b0100);

        // write access
        grp_a_addr_ack = 1'b1;
        step();
        grp_a_addr_ack = 1'b0;
        expect_out("R4 write ack", 1'b1, 1, 4'b0001);
        step(); step();
        expect_out("R4 held level no new irq", 1'b1, 1, 4'b0001);

        // multibyte read with pair resample
        rd_active = 1'b1;
        grp_a_addr_ack = 1'b1;
        step();
        grp_a_addr_ack = 1'b0;
        expect_out("R4 empty flags", 1'b1, 1, 4'b0000);
        port_lvl = 4'b1100;
        step();
        pair_ack = 1'b1;
        step();
        pair_ack = 1'b0;
        expect_out("R8 pair flags", 1'b1, 1, 4'b0010);
        rd_active = 1'b0;
        stop_det = 1'b1;
        step();
        stop_det = 1'b0;
        expect_out("R8 stop suppressed", 1'b1, 1, 4'b0010);
        step();
        expect_out("R8 still quiet", 1'b1, 1, 4'b0010);

        // abandoned access
        port_lvl = 4'b0100;
        step();
        expect_out("R2 second change", 1'b0, 0, 4'b0000);
        rd_active = 1'b1;
        addr_nack = 1'b1;
        step();
        addr_nack = 1'b0;
        rd_active = 1'b0;
        expect_out("R9 nack keeps irq", 1'b0, 1, 4'b0010);
        stop_det = 1'b1;
        step();
        stop_det = 1'b0;
        expect_out("R10 stop no release", 1'b0, 1, 4'b0010);
        pair_ack = 1'b1;
        rd_active = 1'b1;
        step();
        pair_ack = 1'b0;
        expect_out("R10 pair no release", 1'b0, 1, 4'b1000);
        grp_a_addr_ack = 1'b1;
        step();
        grp_a_addr_ack = 1'b0;
        expect_out("R9 flags after nack", 1'b1, 1, 4'b0000);

        // transient inside a read, pending at stop
        port_lvl = 4'b0101;
        step();
        port_lvl = 4'b0100;
        step();
        expect_out("R6 transient in read", 1'b1, 1, 4'b0000);
        rd_active = 1'b0;
        stop_det = 1'b1;
        step();
        stop_det = 1'b0;
        expect_out("R7 reverted change at stop", 1'b0, 1, 4'b0000);

        step();
        step();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule